// File: doc/BRIEF.md
# Flash Query-Mode Probe Sequencer

This block is a small bus master for a parallel NOR flash bank. When it gets a probe request, it writes a short series of command words that should put the bank into query mode. It then reads three identification locations and compares each one with the expected signature characters. If any location does not match, it goes on to the next entry in a fixed list of alternative unlock-and-entry sequences. It stops at the first attempt that gets an answer and reports whether the bank was found and which attempt succeeded. A second request runs a short exit sequence that returns the bank to normal array reads.

The bank is described by two static geometry inputs:
- `dev_lg` is log2 of the bytes per device.
- `ilv_lg` is log2 of the number of devices in parallel.

The block scales every logical command offset to a physical byte address from these inputs. When the devices together are wider than the data bus, it applies the narrow-bus compatibility adjustment. It also copies each command byte into every device lane of the bus word.

The memory port is synchronous:
- A cycle with `mem_we` high is a write.
- A cycle with `mem_re` high is a read request, and its data is returned on `mem_rdata` in the following cycle.

The controller has six states:
- `S_IDLE` waits for a request.
- `S_WRITE` drives one command write.
- `S_GAP` is a one-cycle release between writes.
- `S_READ` issues one signature read.
- `S_CHECK` compares the returned word.
- `S_FINISH` raises the completion pulse.

The transitions are:
- IDLE→WRITE on a probe or exit request.
- WRITE→GAP when the hold count runs out.
- GAP→WRITE for the next write of the same sequence.
- GAP→READ after the last write of a probe attempt.
- GAP→FINISH after the last exit write.
- READ→CHECK always.
- CHECK→READ on a matching character that is not the third.
- CHECK→FINISH on the third matching character, or on a mismatch in the final attempt.
- CHECK→WRITE on a mismatch with attempts left.
- FINISH→IDLE always.

Top module: `qprobe_seq`

## Requirements
- R1: Every command address equals `flash_base + ofs * 2^dev_lg * 2^ilv_lg`, where `ofs` is the logical offset.
- R2: When `dev_lg + ilv_lg` exceeds log2 of the bus width in bytes and the low byte of `ofs` is 0xAA, the value `(2^dev_lg / 2) * 2^ilv_lg` is ORed into the scaled offset before `flash_base` is added.
- R3: The write data splits into lanes of `BUS_BYTES / 2^ilv_lg` bytes. Each lane holds the command byte in its lowest byte, and its other bytes are zero.
- R4: Attempt 0 writes 0xF0 at offset 0, then 0x98 at offset 0x55.
- R5: After the writes of an attempt, the block reads offsets 0x10, 0x11 and 0x12 in that order. The three words must equal the lane-replicated bytes 0x51, 0x52 and 0x59, and a single mismatch fails the attempt.
- R6: The attempts after attempt 0 run in this order:
  - attempt 1: 0xF0@0, 0xFF@0, 0x98@0x55
  - attempt 2: 0xF0@0, 0x98@0x555
  - attempt 3: 0xF0@0, 0xAA@0x5555, 0x55@0x2AAA, 0x98@0x5555
  - attempt 4: 0xF0@0, 0xAA@0x555, 0x55@0x2AA, 0x98@0x555
- R7: The probe ends at the first attempt whose signature matches, with `found`=1 and `attempt_idx` set to that attempt's number. If all five attempts fail, it ends with `found`=0 and `attempt_idx`=0.
- R8: An exit request writes 0xF0@0 then 0xFF@0, plus one more 0xF0@0 when `exit_quirk` is high at the request. The exit clears `found` and `attempt_idx`.
- R9: Each write holds `mem_we` high for exactly `STROBE_CYC` cycles with stable address and data. `mem_we` is low for at least one cycle between consecutive writes.
- R10: `done` is high for exactly one cycle at the end of each probe and each exit.
- R11: A probe or exit request that arrives while a sequence is running is ignored. It adds no writes and no `done` pulse. If both requests arrive together in idle, the probe runs.
- R12: A synchronous reset returns the block to idle with `found`=0, `attempt_idx`=0, `done`=0 and both strobes low, including in the middle of a run.
- R13: The word on `mem_rdata` in the cycle after `mem_re` is the one that gets compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_probe | input | 1 | Request a query-mode probe |
| start_exit | input | 1 | Request the exit sequence |
| exit_quirk | input | 1 | Add a trailing reset write to the exit sequence |
| dev_lg | input | 2 | log2 of the bytes per device (0..2) |
| ilv_lg | input | 2 | log2 of the number of interleaved devices |
| flash_base | input | ADDR_W | Base byte address of the bank |
| mem_addr | output | ADDR_W | Memory port address |
| mem_wdata | output | 8*BUS_BYTES | Memory port write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8*BUS_BYTES | Read data, valid one cycle after `mem_re` |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Signature matched in the last probe |
| attempt_idx | output | 3 | Number of the attempt that matched |

## Verification
The bench model of the flash answers with the signature only during one chosen attempt. It also checks every write address and data word against its own scaling arithmetic, so errors show up as follows:
- A wrong fallback order, or a missing reset write, gives the wrong attempt number or write count.
- A missing compatibility bit gives wrong addresses on the 0x2AAA and 0x2AA writes in the wide geometries.

A signature that is correct except for its last character must lead to not-found. A design that only compared the first read would wrongly report success.

Three more corner cases are covered:
- Requests sent in the middle of a long probe must not add writes or a second `done` pulse.
- The quirk exit must add exactly one write.
- A reset in the middle of a run must silence both strobes at once.

// File: rtl/qprobe_pkg.sv
package qprobe_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WRITE,
        S_GAP,
        S_READ,
        S_CHECK,
        S_FINISH
    } state_t;

    typedef struct packed {
        logic [7:0]  cmd;
        logic [15:0] ofs;
        logic        last;
    } step_t;

    localparam logic [4:0] EXIT_FIRST    = 5'd15;
    localparam logic [4:0] EXIT_PLAIN_END = 5'd16;
    localparam logic [2:0] LAST_TRY      = 3'd4;

    // Flat command table: probe attempts 0..4 occupy steps 0..14 (last marks
    // the final write of each attempt), the exit sequence occupies 15..17.
    function automatic step_t step_at(input logic [4:0] idx);
        step_t s;
        s = '{cmd: 8'hF0, ofs: 16'h0000, last: 1'b0};
        case (idx)
            5'd1:  s = '{cmd: 8'h98, ofs: 16'h0055, last: 1'b1};
            5'd3:  s = '{cmd: 8'hFF, ofs: 16'h0000, last: 1'b0};
            5'd4:  s = '{cmd: 8'h98, ofs: 16'h0055, last: 1'b1};
            5'd6:  s = '{cmd: 8'h98, ofs: 16'h0555, last: 1'b1};
            5'd8:  s = '{cmd: 8'hAA, ofs: 16'h5555, last: 1'b0};
            5'd9:  s = '{cmd: 8'h55, ofs: 16'h2AAA, last: 1'b0};
            5'd10: s = '{cmd: 8'h98, ofs: 16'h5555, last: 1'b1};
            5'd12: s = '{cmd: 8'hAA, ofs: 16'h0555, last: 1'b0};
            5'd13: s = '{cmd: 8'h55, ofs: 16'h02AA, last: 1'b0};
            5'd14: s = '{cmd: 8'h98, ofs: 16'h0555, last: 1'b1};
            5'd16: s = '{cmd: 8'hFF, ofs: 16'h0000, last: 1'b0};
            5'd17: s = '{cmd: 8'hF0, ofs: 16'h0000, last: 1'b1};
            default: s = '{cmd: 8'hF0, ofs: 16'h0000, last: 1'b0};
        endcase
        return s;
    endfunction

    function automatic logic [7:0] sig_char(input logic [1:0] k);
        logic [7:0] c;
        case (k)
            2'd0:    c = 8'h51;
            2'd1:    c = 8'h52;
            default: c = 8'h59;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/qprobe_addr_scale.sv
module qprobe_addr_scale #(
    parameter int ADDR_W    = 24,
    parameter int BUS_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [15:0]       ofs,
    input  logic [1:0]        dev_lg,
    input  logic [1:0]        ilv_lg,
    output logic [ADDR_W-1:0] phys
);
    localparam int BUS_LG = $clog2(BUS_BYTES);

    logic [2:0]        sh;
    logic              compat;
    logic [ADDR_W-1:0] wide;
    logic [ADDR_W-1:0] extra;

    always_comb begin
        sh     = {1'b0, dev_lg} + {1'b0, ilv_lg};
        wide   = ADDR_W'(ofs) << sh;
        compat = (int'(sh) > BUS_LG) && (ofs[7:0] == 8'hAA);
        extra  = '0;
        if (compat && (dev_lg != 2'd0))
            extra = ADDR_W'(1) << ({1'b0, dev_lg} - 3'd1 + {1'b0, ilv_lg});
        phys   = base + (wide | extra);
    end
endmodule

// File: rtl/qprobe_lane_rep.sv
module qprobe_lane_rep #(
    parameter int BUS_BYTES = 4
) (
    input  logic [7:0]             code,
    input  logic [1:0]             ilv_lg,
    output logic [8*BUS_BYTES-1:0] word
);
    localparam int BUS_LG = $clog2(BUS_BYTES);

    logic [1:0] il_eff;
    logic [7:0] lane_mask;

    always_comb begin
        il_eff    = (int'(ilv_lg) > BUS_LG) ? 2'(BUS_LG) : ilv_lg;
        lane_mask = 8'((BUS_BYTES >> il_eff) - 1);
    end

    for (genvar b = 0; b < BUS_BYTES; b++) begin : g_byte
        assign word[8*b +: 8] = ((8'(b) & lane_mask) == 8'h00) ? code : 8'h00;
    end
endmodule

// File: rtl/qprobe_hold_timer.sv
module qprobe_hold_timer #(
    parameter int HOLD = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic zero
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CW'(HOLD - 1);
        else if (run && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/qprobe_seq.sv
module qprobe_seq
    import qprobe_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int BUS_BYTES  = 4,
    parameter int STROBE_CYC = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_probe,
    input  logic                   start_exit,
    input  logic                   exit_quirk,
    input  logic [1:0]             dev_lg,
    input  logic [1:0]             ilv_lg,
    input  logic [ADDR_W-1:0]      flash_base,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [8*BUS_BYTES-1:0] mem_wdata,
    output logic                   mem_we,
    output logic                   mem_re,
    input  logic [8*BUS_BYTES-1:0] mem_rdata,
    output logic                   done,
    output logic                   found,
    output logic [2:0]             attempt_idx
);
    localparam int DATA_W = 8 * BUS_BYTES;

    state_t     state_q, state_d;
    logic [4:0] step_q, step_d;
    logic [2:0] try_q, try_d;
    logic [1:0] chr_q, chr_d;
    logic       exit_q, exit_d;
    logic       quirk_q, quirk_d;
    logic       found_q, found_d;
    logic [2:0] idx_q, idx_d;

    step_t             cur;
    logic [15:0]       ofs_sel;
    logic [ADDR_W-1:0] phys;
    logic [DATA_W-1:0] cmd_word;
    logic [DATA_W-1:0] sig_word;
    logic              sig_hit;
    logic              hold_zero;
    logic              hold_load;
    logic              exit_end;

    assign cur     = step_at(step_q);
    assign ofs_sel = (state_q == S_READ) ? (16'h0010 + 16'(chr_q)) : cur.ofs;

    qprobe_addr_scale #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_scale (
        .base   (flash_base),
        .ofs    (ofs_sel),
        .dev_lg (dev_lg),
        .ilv_lg (ilv_lg),
        .phys   (phys)
    );

    qprobe_lane_rep #(.BUS_BYTES(BUS_BYTES)) u_cmd_rep (
        .code   (cur.cmd),
        .ilv_lg (ilv_lg),
        .word   (cmd_word)
    );

    qprobe_lane_rep #(.BUS_BYTES(BUS_BYTES)) u_sig_rep (
        .code   (sig_char(chr_q)),
        .ilv_lg (ilv_lg),
        .word   (sig_word)
    );

    qprobe_hold_timer #(.HOLD(STROBE_CYC)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (hold_load),
        .run  (state_q == S_WRITE),
        .zero (hold_zero)
    );

    // R13: the compare uses the word returned one cycle after the read strobe
    assign sig_hit   = (mem_rdata == sig_word);
    assign exit_end  = cur.last || ((step_q == EXIT_PLAIN_END) && !quirk_q);
    assign hold_load = (state_d == S_WRITE) && (state_q != S_WRITE);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        try_d   = try_q;
        chr_d   = chr_q;
        exit_d  = exit_q;
        quirk_d = quirk_q;
        found_d = found_q;
        idx_d   = idx_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_probe) begin
                    state_d = S_WRITE;
                    step_d  = 5'd0;
                    try_d   = 3'd0;
                    exit_d  = 1'b0;
                    found_d = 1'b0;
                    idx_d   = 3'd0;
                end else if (start_exit) begin
                    state_d = S_WRITE;
                    step_d  = EXIT_FIRST;
                    exit_d  = 1'b1;
                    quirk_d = exit_quirk;
                    found_d = 1'b0;
                    idx_d   = 3'd0;
                end
            end
            S_WRITE: begin
                if (hold_zero) state_d = S_GAP;
            end
            S_GAP: begin
                if (exit_q) begin
                    if (exit_end) begin
                        state_d = S_FINISH;
                    end else begin
                        step_d  = step_q + 5'd1;
                        state_d = S_WRITE;
                    end
                end else if (cur.last) begin
                    chr_d   = 2'd0;
                    state_d = S_READ;
                end else begin
                    step_d  = step_q + 5'd1;
                    state_d = S_WRITE;
                end
            end
            S_READ: begin
                state_d = S_CHECK;
            end
            S_CHECK: begin
                if (!sig_hit) begin
                    if (try_q == LAST_TRY) begin
                        state_d = S_FINISH;
                    end else begin
                        try_d   = try_q + 3'd1;
                        step_d  = step_q + 5'd1;
                        state_d = S_WRITE;
                    end
                end else if (chr_q == 2'd2) begin
                    found_d = 1'b1;
                    idx_d   = try_q;
                    state_d = S_FINISH;
                end else begin
                    chr_d   = chr_q + 2'd1;
                    state_d = S_READ;
                end
            end
            S_FINISH: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            step_q  <= '0;
            try_q   <= '0;
            chr_q   <= '0;
            exit_q  <= 1'b0;
            quirk_q <= 1'b0;
            found_q <= 1'b0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            try_q   <= try_d;
            chr_q   <= chr_d;
            exit_q  <= exit_d;
            quirk_q <= quirk_d;
            found_q <= found_d;
            idx_q   <= idx_d;
        end
    end

    // Outputs
    always_comb begin
        mem_we      = (state_q == S_WRITE);
        mem_re      = (state_q == S_READ);
        done        = (state_q == S_FINISH);
        mem_addr    = phys;
        mem_wdata   = cmd_word;
        found       = found_q;
        attempt_idx = idx_q;
    end

    assert_write_held_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_found_at_end_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(found) |-> done);

    assert_read_then_compare_R13: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> (!mem_re && !mem_we));

    assert_mode_kept_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_IDLE) |=> ((state_q == S_IDLE) || $stable(exit_q)));

endmodule

// File: tb/qprobe_seq_tb.sv
module qprobe_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 24;
    localparam int BUS_BYTES  = 4;
    localparam int STROBE_CYC = 3;
    localparam int DW         = 8 * BUS_BYTES;
    localparam logic [ADDR_W-1:0] BASE = 24'h100000;

    // expected command table (R4, R6, R8)
    localparam logic [7:0] PCMD [18] = '{8'hF0, 8'h98, 8'hF0, 8'hFF, 8'h98, 8'hF0, 8'h98,
        8'hF0, 8'hAA, 8'h55, 8'h98, 8'hF0, 8'hAA, 8'h55, 8'h98, 8'hF0, 8'hFF, 8'hF0};
    localparam int POFS [18] = '{0, 'h55, 0, 0, 'h55, 0, 'h555, 0, 'h5555, 'h2AAA, 'h5555,
        0, 'h555, 'h2AA, 'h555, 0, 0, 0};

    // dev_lg, ilv_lg, accepting attempt (5 = never), found, idx, writes
    localparam int VEC [7][6] = '{
        '{0, 0, 0, 1, 0, 2},
        '{1, 1, 1, 1, 1, 5},
        '{2, 0, 2, 1, 2, 7},
        '{2, 1, 3, 1, 3, 11},
        '{1, 2, 4, 1, 4, 15},
        '{0, 2, 5, 0, 0, 15},
        '{0, 1, 2, 1, 2, 7}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start_probe = 1'b0;
    logic            start_exit = 1'b0;
    logic            exit_quirk = 1'b0;
    logic [1:0]      dev_lg = 2'd0;
    logic [1:0]      ilv_lg = 2'd0;
    logic [ADDR_W-1:0] mem_addr;
    logic [DW-1:0]   mem_wdata;
    logic            mem_we;
    logic            mem_re;
    logic [DW-1:0]   mem_rdata = '0;
    logic            done;
    logic            found;
    logic [2:0]      attempt_idx;

    int n_checks = 0;
    int n_err = 0;
    int cur_try = -1;
    int accept = 5;
    bit corrupt_y = 1'b0;
    int exp_ptr = 0;
    int wr_count = 0;
    int wr_bad = 0;
    int len_bad = 0;
    int hi_len = 0;
    int done_cnt = 0;
    bit we_d = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qprobe_seq #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES), .STROBE_CYC(STROBE_CYC)) u_dut (
        .clk(clk), .rst(rst), .start_probe(start_probe), .start_exit(start_exit),
        .exit_quirk(exit_quirk), .dev_lg(dev_lg), .ilv_lg(ilv_lg), .flash_base(BASE),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .done(done), .found(found), .attempt_idx(attempt_idx)
    );

    function automatic logic [DW-1:0] rep(input logic [7:0] c, input int il);
        logic [DW-1:0] w;
        int lw;
        w = '0;
        lw = BUS_BYTES >> il;
        for (int b = 0; b < BUS_BYTES; b++)
            if (b % lw == 0) w[8*b +: 8] = c;
        return w;
    endfunction

    function automatic logic [ADDR_W-1:0] scale(input int ofs, input int dv, input int il);
        int dev;
        int ilv;
        int a;
        dev = 1 << dv;
        ilv = 1 << il;
        a = ofs * dev * ilv;
        if ((dev * ilv > BUS_BYTES) && (ofs % 256 == 170)) a = a | ((dev / 2) * ilv);
        return BASE + ADDR_W'(a);
    endfunction

    function automatic logic [DW-1:0] flash_val(input logic [ADDR_W-1:0] a);
        int dv;
        int il;
        dv = int'(dev_lg);
        il = int'(ilv_lg);
        if (cur_try != accept) return '0;
        if (a == scale('h10, dv, il)) return rep(8'h51, il);
        if (a == scale('h11, dv, il)) return rep(8'h52, il);
        if (a == scale('h12, dv, il)) return corrupt_y ? rep(8'h58, il) : rep(8'h59, il);
        return '0;
    endfunction

    // flash model and write monitor (R1, R2, R3, R9, R13)
    always @(posedge clk) begin
        if (!rst) begin
            if (mem_we && !we_d) begin
                wr_count++;
                if (exp_ptr < 18) begin
                    if (mem_addr != scale(POFS[exp_ptr], int'(dev_lg), int'(ilv_lg)) ||
                        mem_wdata != rep(PCMD[exp_ptr], int'(ilv_lg)))
                        wr_bad++;
                end else begin
                    wr_bad++;
                end
                exp_ptr++;
                if (mem_addr == BASE && mem_wdata == rep(8'hF0, int'(ilv_lg))) cur_try++;
            end
            if (mem_we) hi_len++;
            else if (we_d) begin
                if (hi_len != STROBE_CYC) len_bad++;
                hi_len = 0;
            end
            if (done) done_cnt++;
        end
        mem_rdata <= mem_re ? flash_val(mem_addr) : '0;
        we_d = mem_we;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        wr_count = 0;
        wr_bad = 0;
        len_bad = 0;
        done_cnt = 0;
    endtask

    task automatic wait_done();
        for (int g = 0; g < 4000 && done_cnt == 0; g++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic run_probe(input int acc);
        accept = acc;
        cur_try = -1;
        exp_ptr = 0;
        clear_counts();
        @(negedge clk) start_probe = 1'b1;
        @(negedge clk) start_probe = 1'b0;
        wait_done();
    endtask

    task automatic run_exit(input bit q);
        exp_ptr = 15;
        clear_counts();
        @(negedge clk) begin start_exit = 1'b1; exit_quirk = q; end
        @(negedge clk) begin start_exit = 1'b0; exit_quirk = 1'b0; end
        wait_done();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 reset found", 32'(found), 0);
        check("R12 reset idx", 32'(attempt_idx), 0);
        check("R12 reset done", 32'(done), 0);
        check("R12 reset we", 32'(mem_we), 0);
        check("R12 reset re", 32'(mem_re), 0);

        // table walk: geometries and accepting attempts (R1..R7, R9, R10, R13)
        for (int v = 0; v < 7; v++) begin
            dev_lg = 2'(VEC[v][0]);
            ilv_lg = 2'(VEC[v][1]);
            run_probe(VEC[v][2]);
            check("R7 found", 32'(found), 32'(VEC[v][3]));
            check("R7 attempt index", 32'(attempt_idx), 32'(VEC[v][4]));
            check("R6 write count", 32'(wr_count), 32'(VEC[v][5]));
            check("R1 R2 R3 R4 write addr/data mismatches", 32'(wr_bad), 0);
            check("R9 strobe length errors", 32'(len_bad), 0);
            check("R10 done pulses", 32'(done_cnt), 1);
        end

        // R5: last signature character wrong in the answering attempt
        dev_lg = 2'd1;
        ilv_lg = 2'd0;
        corrupt_y = 1'b1;
        run_probe(0);
        check("R5 partial signature found", 32'(found), 0);
        check("R5 partial signature writes", 32'(wr_count), 15);
        corrupt_y = 1'b0;

        // R11: requests during a long probe are ignored
        accept = 4;
        cur_try = -1;
        exp_ptr = 0;
        clear_counts();
        @(negedge clk) start_probe = 1'b1;
        @(negedge clk) start_probe = 1'b0;
        repeat (6) @(negedge clk);
        start_exit = 1'b1;
        @(negedge clk) start_exit = 1'b0;
        repeat (10) @(negedge clk);
        start_probe = 1'b1;
        @(negedge clk) start_probe = 1'b0;
        wait_done();
        repeat (30) @(negedge clk);
        check("R11 writes with busy requests", 32'(wr_count), 15);
        check("R11 write sequence intact", 32'(wr_bad), 0);
        check("R11 single done", 32'(done_cnt), 1);
        check("R11 found idx", 32'(attempt_idx), 4);

        // R8: exit sequences
        run_exit(1'b0);
        check("R8 exit writes", 32'(wr_count), 2);
        check("R8 exit data", 32'(wr_bad), 0);
        check("R8 exit clears found", 32'(found), 0);
        check("R10 exit done", 32'(done_cnt), 1);
        run_exit(1'b1);
        check("R8 quirk exit writes", 32'(wr_count), 3);
        check("R8 quirk exit data", 32'(wr_bad), 0);

        // R11: both requests together in idle -> probe
        accept = 0;
        cur_try = -1;
        exp_ptr = 0;
        clear_counts();
        @(negedge clk) begin start_probe = 1'b1; start_exit = 1'b1; end
        @(negedge clk) begin start_probe = 1'b0; start_exit = 1'b0; end
        wait_done();
        check("R11 simultaneous requests probe wins", 32'(found), 1);
        check("R11 simultaneous writes", 32'(wr_bad), 0);

        // R12: reset after success, and in the middle of a run
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check("R12 reset clears found", 32'(found), 0);
        check("R12 reset clears idx", 32'(attempt_idx), 0);
        accept = 5;
        cur_try = -1;
        exp_ptr = 0;
        @(negedge clk) start_probe = 1'b1;
        @(negedge clk) start_probe = 1'b0;
        repeat (9) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R12 mid-run reset we", 32'(mem_we), 0);
        check("R12 mid-run reset re", 32'(mem_re), 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        check("R12 idle after reset", 32'(mem_we | mem_re | done), 0);
        run_probe(0);
        check("R12 probe after reset", 32'(found), 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule